// File: doc/BRIEF.md
# Count-Bounded UART Transmitter

This block is the transmit half of a serial port that sends a fixed number of characters per transfer. Software first writes a character count. It then writes characters one at a time into a small transmit queue, and the block shifts each one out as an asynchronous serial frame. The frame has one start bit, eight data bits sent least significant bit first, and one stop bit. A baud tick arrives on a separate input, and each bit on the line lasts sixteen of those ticks.

When the last character of the programmed count has left the line, a sticky transfer-done flag rises in the interrupt-status word. The flag stays set until software clears it with a command. The status word also shows whether the transmitter is fully empty, meaning the queue holds nothing and no frame is in flight. A reset command aborts the transfer in progress, discards the queue and returns the line to idle.

Top module: `cnt_uart_tx`

## Requirements
- R1: The line idles high. Each character goes out as a low start bit, then data bits 0 to 7 in that order, then a high stop bit. Every bit lasts 16 baud ticks. Only bits [7:0] of a queue write are sent.
- R2: A queue write is accepted only while the count still allows characters. Writes made with no count programmed, and writes beyond the programmed count, are dropped and are never sent.
- R3: Interrupt-status bit 7 sets once the stop bit of the last counted character has ended. It does not set earlier, and it does not set while fewer characters than the count have been written.
- R4: Interrupt-status bit 7 stays set until it is cleared by command. Commands whose bits [11:8] are not 3 leave it set.
- R5: A command whose bits [11:8] equal 3 clears interrupt-status bit 7.
- R6: Status bit 3 is 1 exactly when the queue is empty and no frame is being sent. All other status bits read 0.
- R7: A command whose bits [7:4] equal 2 (value 0x20) aborts the current frame and drives the line high at once. It also discards the queued characters and cancels the remaining count, so no transfer-done flag follows.
- R8: Writing a new count re-arms the block, so a following transfer of that many characters proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick, 16 per bit time |
| cnt_we_i | input | 1 | Character-count write strobe |
| cnt_wdata_i | input | CNT_W | Number of characters in the next transfer |
| fifo_we_i | input | 1 | Transmit queue write strobe |
| fifo_wdata_i | input | BUS_W | Queue write data, bits [7:0] are the character |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | BUS_W | Command word |
| status_o | output | 8 | Status, bit 3 = transmitter empty |
| isr_o | output | 8 | Interrupt status, bit 7 = transfer done |
| txd_o | output | 1 | Serial output line |

## Verification
The hardest state to reach is the reset command arriving while a frame is half shifted and more characters are still queued. The bench times that command after the start bit is visible on the line. It then watches the line for more than two frame times to show that nothing further leaves, and that neither the done flag nor a stray low bit appears. A second hard case is a transfer whose count is not yet met. Here the bench writes one character fewer than programmed and confirms the flag stays low, then supplies the last character. Random transfers with extra writes beyond the count and random upper data bits complete the coverage.

// File: rtl/cnt_uart_tx_pkg.sv
package cnt_uart_tx_pkg;
  localparam int unsigned FRAME_EXTRA = 2;  // start + stop

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SEND = 1'b1} sh_state_e;

  function automatic logic is_clr_ready(input logic [3:0] op_hi);
    return op_hi == 4'd3;
  endfunction

  function automatic logic is_reset_tx(input logic [3:0] op_lo);
    return op_lo == 4'd2;
  endfunction
endpackage

// File: rtl/cnt_uart_tx_fifo.sv
module cnt_uart_tx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned PW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + PW'(1);
      if (pop_i)  rd_q <= rd_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  initial begin
    depth_pow2_chk: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 2);
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/cnt_uart_tx_shifter.sv
module cnt_uart_tx_shifter
  import cnt_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OS     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_BITS = DATA_W + FRAME_EXTRA;
  localparam int unsigned TW = (OS > 1) ? $clog2(OS) : 1;
  localparam int unsigned BW = $clog2(FRAME_BITS);

  sh_state_e         state_q;
  logic [DATA_W:0]   shreg_q;   // data bits then stop bit
  logic [TW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic              line_q, done_q;
  logic              bit_end, last_bit;

  assign bit_end  = (state_q == ST_SEND) && tick_i && (tcnt_q == TW'(OS - 1));
  assign last_bit = (bcnt_q == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      line_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
        bcnt_q  <= '0;
        line_q  <= 1'b1;
      end else if (state_q == ST_IDLE) begin
        if (load_i) begin
          state_q <= ST_SEND;
          shreg_q <= {1'b1, data_i};
          tcnt_q  <= '0;
          bcnt_q  <= '0;
          line_q  <= 1'b0;   // start bit
        end
      end else if (tick_i) begin
        if (bit_end) begin
          tcnt_q <= '0;
          if (last_bit) begin
            state_q <= ST_IDLE;
            line_q  <= 1'b1;
            done_q  <= 1'b1;
          end else begin
            line_q  <= shreg_q[0];
            shreg_q <= {1'b1, shreg_q[DATA_W:1]};
            bcnt_q  <= bcnt_q + BW'(1);
          end
        end else begin
          tcnt_q <= tcnt_q + TW'(1);
        end
      end
    end
  end

  assign busy_o = (state_q == ST_SEND);
  assign done_o = done_q;
  assign txd_o  = line_q;

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  // R1
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  // R7
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && txd_o && !done_o));
endmodule

// File: rtl/cnt_uart_tx_ctrl.sv
module cnt_uart_tx_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             fifo_we_i,
  input  logic             fifo_full_i,
  input  logic             frame_done_i,
  input  logic             clr_ready_i,
  input  logic             reset_tx_i,
  output logic             push_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] accept_q, send_q;
  logic             ready_q, ready_set;

  assign push_o    = fifo_we_i && !fifo_full_i && (accept_q != '0)
                     && !cnt_we_i && !reset_tx_i;
  assign ready_set = frame_done_i && (send_q == CNT_W'(1))
                     && !cnt_we_i && !reset_tx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= '0;
      send_q   <= '0;
      ready_q  <= 1'b0;
    end else begin
      if (reset_tx_i) begin
        accept_q <= '0;
        send_q   <= '0;
      end else if (cnt_we_i) begin
        accept_q <= cnt_wdata_i;
        send_q   <= cnt_wdata_i;
      end else begin
        if (push_o) accept_q <= accept_q - CNT_W'(1);
        if (frame_done_i && send_q != '0) send_q <= send_q - CNT_W'(1);
      end
      if (ready_set)        ready_q <= 1'b1;
      else if (clr_ready_i) ready_q <= 1'b0;
    end
  end

  assign ready_o = ready_q;

  // R2
  cnt_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_q <= send_q);

  // R4
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !clr_ready_i) |=> ready_o);

  // R5
  ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ready_i && !frame_done_i) |=> !ready_o);
endmodule

// File: rtl/cnt_uart_tx.sv
module cnt_uart_tx
  import cnt_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned OS     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             fifo_we_i,
  input  logic [BUS_W-1:0] fifo_wdata_i,
  input  logic             cmd_we_i,
  input  logic [BUS_W-1:0] cmd_wdata_i,
  output logic [7:0]       status_o,
  output logic [7:0]       isr_o,
  output logic             txd_o
);
  logic              clr_ready, reset_tx, push, pop;
  logic              fifo_empty, fifo_full, busy, done, ready, tx_empty;
  logic [DATA_W-1:0] head;
  logic              unused_bits;

  assign unused_bits = ^{fifo_wdata_i[BUS_W-1:DATA_W], cmd_wdata_i[BUS_W-1:12],
                         cmd_wdata_i[3:0]};

  assign clr_ready = cmd_we_i && is_clr_ready(cmd_wdata_i[11:8]);
  assign reset_tx  = cmd_we_i && is_reset_tx(cmd_wdata_i[7:4]);
  assign pop       = !busy && !fifo_empty && !reset_tx;

  cnt_uart_tx_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk_i, .rst_ni,
    .cnt_we_i, .cnt_wdata_i, .fifo_we_i,
    .fifo_full_i (fifo_full),
    .frame_done_i(done),
    .clr_ready_i (clr_ready),
    .reset_tx_i  (reset_tx),
    .push_o      (push),
    .ready_o     (ready)
  );

  cnt_uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (fifo_wdata_i[DATA_W-1:0]),
    .pop_i  (pop),
    .flush_i(reset_tx),
    .data_o (head),
    .empty_o(fifo_empty),
    .full_o (fifo_full)
  );

  cnt_uart_tx_shifter #(.DATA_W(DATA_W), .OS(OS)) shift_i (
    .clk_i, .rst_ni, .tick_i,
    .load_i (pop),
    .data_i (head),
    .abort_i(reset_tx),
    .busy_o (busy),
    .done_o (done),
    .txd_o
  );

  assign tx_empty = fifo_empty && !busy;
  assign status_o = {4'b0, tx_empty, 3'b0};
  assign isr_o    = {ready, 7'b0};

  // R3
  ready_needs_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready) |-> tx_empty);

  // R7
  reset_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_tx |=> (status_o[3] && !$rose(isr_o[7])));
endmodule

// File: tb/cnt_uart_tx_tb_top.sv
module cnt_uart_tx_tb_top;
  localparam int CNT_W = 16;
  localparam int BUS_W = 32;
  localparam int HALF  = 5;     // 100 MHz
  localparam int BITC  = 64;    // 16 ticks x 4 cycles

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic cnt_we_i = 1'b0, fifo_we_i = 1'b0, cmd_we_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic [BUS_W-1:0] fifo_wdata_i = '0, cmd_wdata_i = '0;
  logic [7:0] status_o, isr_o;
  logic txd_o;

  int checks = 0, errors = 0;
  logic [7:0] rx_buf [64];
  logic [7:0] exp_buf [64];
  int rx_cnt = 0, exp_cnt = 0;
  bit mon_on = 1'b1;
  logic [1:0] tdiv = '0;

  always #HALF clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd2);
  end

  cnt_uart_tx dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .cnt_we_i, .cnt_wdata_i,
    .fifo_we_i, .fifo_wdata_i, .cmd_we_i, .cmd_wdata_i,
    .status_o, .isr_o, .txd_o
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // line monitor: samples mid-bit on falling clock edges
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on && prev && !txd_o) begin
        logic [7:0] b;
        logic ok;
        repeat (BITC/2) @(negedge clk);
        ok = !txd_o;
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = txd_o;
        end
        repeat (BITC) @(negedge clk);
        ok = ok && txd_o;
        check(ok, "R1 frame start/stop", {31'd0, ok}, 1);
        if (rx_cnt < 64) rx_buf[rx_cnt] = b;
        rx_cnt++;
      end
      prev = txd_o;
    end
  end

  task automatic w_cnt(input int n);
    @(posedge clk); #1 cnt_we_i = 1'b1; cnt_wdata_i = CNT_W'(n);
    @(posedge clk); #1 cnt_we_i = 1'b0;
  endtask

  task automatic w_data(input logic [7:0] d, input bit expect_sent);
    @(posedge clk); #1 fifo_we_i = 1'b1;
    fifo_wdata_i = {$urandom(), d} ;
    fifo_wdata_i[7:0] = d;
    @(posedge clk); #1 fifo_we_i = 1'b0;
    if (expect_sent) begin exp_buf[exp_cnt] = d; exp_cnt++; end
  endtask

  task automatic w_cmd(input logic [31:0] c);
    @(posedge clk); #1 cmd_we_i = 1'b1; cmd_wdata_i = c;
    @(posedge clk); #1 cmd_we_i = 1'b0;
  endtask

  task automatic wait_rx(input int n, input int limit);
    for (int i = 0; i < limit && rx_cnt < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !isr_o[7]; i++) @(negedge clk);
  endtask

  task automatic cmp_data(input string tag);
    check(rx_cnt == exp_cnt, tag, rx_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++)
      check(rx_buf[i] == exp_buf[i], tag, rx_buf[i], exp_buf[i]);
    rx_cnt = 0; exp_cnt = 0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    check(txd_o == 1'b1, "R1 idle high after reset", txd_o, 1);
    check(status_o == 8'h08, "R6 empty after reset", status_o, 8'h08);
    check(isr_o[7] == 1'b0, "R4 done clear after reset", isr_o[7], 0);

    // no count programmed: write dropped
    w_data(8'hC3, 0);
    repeat (900) @(negedge clk);
    check(rx_cnt == 0, "R2 write without count", rx_cnt, 0);
    check(status_o[3] == 1'b1, "R6 still empty", status_o[3], 1);

    // directed two-character transfer
    w_cnt(2);
    w_data(8'h55, 1);
    w_data(8'hA3, 1);
    @(negedge clk);
    check(status_o[3] == 1'b0, "R6 busy while sending", status_o[3], 0);
    wait_rx(2, 3000);
    check(isr_o[7] == 1'b0, "R3 not before stop ends", isr_o[7], 0);
    repeat (40) @(negedge clk);
    check(isr_o[7] == 1'b1, "R3 done after last stop", isr_o[7], 1);
    check(status_o == 8'h08, "R6 empty after transfer", status_o, 8'h08);
    check(txd_o == 1'b1, "R1 idle after transfer", txd_o, 1);
    cmp_data("R1 data bits");

    // sticky flag and clear
    repeat (300) @(negedge clk);
    check(isr_o[7] == 1'b1, "R4 flag holds", isr_o[7], 1);
    w_cmd(32'h0000_0100);
    w_cmd(32'h0000_0400);
    @(negedge clk);
    check(isr_o[7] == 1'b1, "R4 other commands keep flag", isr_o[7], 1);
    w_cmd(32'h0000_0300);
    @(negedge clk);
    check(isr_o[7] == 1'b0, "R5 clear command", isr_o[7], 0);

    // count not met
    w_cnt(2);
    w_data(8'h0F, 1);
    wait_rx(1, 2000);
    repeat (100) @(negedge clk);
    check(isr_o[7] == 1'b0, "R3 no flag on partial transfer", isr_o[7], 0);
    w_data(8'hF0, 1);
    wait_ready(2000);
    check(isr_o[7] == 1'b1, "R3 flag after final char", isr_o[7], 1);
    cmp_data("R3 partial data");
    w_cmd(32'h0000_0300);

    // writes beyond count, then re-arm
    w_cnt(1);
    w_data(8'h11, 1);
    w_data(8'h22, 0);
    w_data(8'h33, 0);
    wait_ready(2000);
    repeat (1500) @(negedge clk);
    cmp_data("R2 writes beyond count dropped");
    w_cmd(32'h0000_0300);
    w_cnt(1);
    w_data(8'h44, 1);
    wait_ready(2000);
    check(isr_o[7] == 1'b1, "R8 new count re-arms", isr_o[7], 1);
    repeat (40) @(negedge clk);
    cmp_data("R8 re-armed data");
    w_cmd(32'h0000_0300);

    // abort mid-frame
    mon_on = 1'b0;
    w_cnt(3);
    w_data(8'h81, 0);
    w_data(8'h7E, 0);
    w_data(8'h99, 0);
    repeat (20) @(negedge clk);
    check(txd_o == 1'b0, "R7 frame started before abort", txd_o, 0);
    repeat (150) @(negedge clk);
    w_cmd(32'h0000_0020);
    @(negedge clk);
    check(txd_o == 1'b1, "R7 line high after abort", txd_o, 1);
    check(status_o == 8'h08, "R7 empty after abort", status_o, 8'h08);
    begin
      int lows = 0;
      for (int i = 0; i < 1600; i++) begin
        @(negedge clk);
        if (!txd_o) lows++;
      end
      check(lows == 0, "R7 nothing sent after abort", lows, 0);
    end
    check(isr_o[7] == 1'b0, "R7 no flag after abort", isr_o[7], 0);
    mon_on = 1'b1;
    rx_cnt = 0; exp_cnt = 0;
    w_cnt(1);
    w_data(8'h5A, 1);
    wait_ready(2000);
    check(isr_o[7] == 1'b1, "R8 transfer after abort", isr_o[7], 1);
    repeat (40) @(negedge clk);
    cmp_data("R7 data after abort");
    w_cmd(32'h0000_0300);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      int n, extra;
      n = 1 + int'($urandom() % 4);
      extra = int'($urandom() % 3);
      w_cnt(n);
      for (int k = 0; k < n; k++) w_data(8'($urandom()), 1);
      for (int k = 0; k < extra; k++) w_data(8'($urandom()), 0);
      wait_ready(4000);
      check(isr_o[7] == 1'b1, "R3 random transfer done", isr_o[7], 1);
      repeat (40) @(negedge clk);
      check(status_o == 8'h08, "R6 random empty", status_o, 8'h08);
      cmp_data("R1 R2 random data");
      w_cmd(32'h0000_0300);
      @(negedge clk);
      check(isr_o[7] == 1'b0, "R5 random clear", isr_o[7], 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule